// File: doc/BRIEF.md
# Configurable System Clock Controller

This block derives the system, PWM and ADC clock enables from a set of configuration fields. Every clock is modelled as a one-cycle enable pulse in a single fast reference domain. The PLL appears as a tick input at the 400 MHz rate, and each oscillator appears as its own tick input. The system path selects one of five sources: the main oscillator, the 12 MHz internal oscillator, that oscillator divided by four, the 30 kHz internal oscillator, or the 32.768 kHz hibernation oscillator. When bypass is clear, the system path uses the PLL tick halved instead. An optional divider then divides the result by its field value plus one.

Three field groups feed the selection. The primary group is the normal one. The secondary group replaces it when its override bit is set. When the deep-sleep input is high, the deep-sleep group replaces source, bypass, divider enable and divider value. The PWM enable follows the system enable, optionally divided by a power of two. The ADC enable is the PLL tick divided by 25.

A new source or divider takes effect only when the current system period ends, so no period is ever cut short. Selecting a source that is switched off, or a reserved code, stops the system enable and raises a status flag.

Top module: `clkctl_top`

## Requirements
- R1: With bypass set, the system enable follows the chosen oscillator by source code: 0 main, 1 internal fast, 2 internal fast divided by four, 3 internal slow, 4 hibernation. Codes 5 to 7 are reserved.
- R2: With bypass clear, the system enable comes from the PLL tick divided by two.
- R3: With the divider enabled, the system enable period is (divider field + 1) periods of the selected base. With it disabled, the base passes through undivided.
- R4: When the secondary override bit is set, source, bypass, divider enable, divider value and PLL power-down are taken from the secondary fields.
- R5: While deep sleep is high, source, bypass, divider enable and divider value are taken from the deep-sleep fields.
- R6: With PWM division enabled, the PWM enable is the system enable divided by 2 << pwm_code. Otherwise it equals the system enable. A PWM pulse only ever coincides with a system pulse.
- R7: The ADC enable fires once every 25 PLL ticks. It is silent while the effective PLL power-down is set.
- R8: Any of the following produces no system enable pulses and sets sel_bad high: a reserved source code, the main oscillator while main_off is set, either internal-fast source while fast_off is set, or the PLL path while powered down.
- R9: A change of source or divider becomes active only at the end of the running system period. The period in progress completes at its old length.
- R10: After reset, the active path is the internal fast oscillator with bypass and no division, and sel_bad is low for that configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| pll_tick | input | 1 | PLL rate tick |
| main_tick | input | 1 | Main oscillator tick |
| fast_tick | input | 1 | Internal 12 MHz oscillator tick |
| slow_tick | input | 1 | Internal 30 kHz oscillator tick |
| hib_tick | input | 1 | Hibernation oscillator tick |
| p_src | input | 3 | Primary source code |
| p_bypass | input | 1 | Primary bypass (1 = oscillator, 0 = PLL) |
| p_use_div | input | 1 | Primary divider enable |
| p_div | input | DIV_W | Primary divider value (ratio = value + 1) |
| p_pd | input | 1 | Primary PLL power-down |
| main_off | input | 1 | Main oscillator disable |
| fast_off | input | 1 | Internal fast oscillator disable |
| pwm_use_div | input | 1 | PWM divider enable |
| pwm_code | input | PWM_CODE_W | PWM divide code (ratio = 2 << code) |
| s_override | input | 1 | Select secondary fields |
| s_src | input | 3 | Secondary source code |
| s_bypass | input | 1 | Secondary bypass |
| s_use_div | input | 1 | Secondary divider enable |
| s_div | input | DIV_W | Secondary divider value |
| s_pd | input | 1 | Secondary PLL power-down |
| dsleep | input | 1 | Deep-sleep mode active |
| d_src | input | 3 | Deep-sleep source code |
| d_bypass | input | 1 | Deep-sleep bypass |
| d_use_div | input | 1 | Deep-sleep divider enable |
| d_div | input | DIV_W | Deep-sleep divider value |
| sys_en | output | 1 | System clock enable pulse |
| pwm_en | output | 1 | PWM clock enable pulse |
| adc_en | output | 1 | ADC clock enable pulse |
| sel_bad | output | 1 | Requested selection is unusable |

## Verification
Some properties are checked by assertions on every cycle:
- every system pulse lines up with a source tick;
- every PWM pulse lines up with a system pulse;
- the ADC pulse appears only on an unpowered-down PLL tick;
- each divider's latched ratio stays put in the middle of a period, and its count stays within that ratio.

Other behaviour only the bench scenarios can show. These are the actual rates for each source code and each divider setting, the precedence of override and deep sleep, the silence of an unusable selection, and the full-length completion of a period after a divider change. The bench shows them by counting pulses over windows whose length is a multiple of every period involved.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;

    localparam logic [2:0] SRC_MAIN   = 3'd0;
    localparam logic [2:0] SRC_FAST   = 3'd1;
    localparam logic [2:0] SRC_FAST_Q = 3'd2;
    localparam logic [2:0] SRC_SLOW   = 3'd3;
    localparam logic [2:0] SRC_HIB    = 3'd4;

    // Source choice of the system path
    typedef struct packed {
        logic [2:0] src;
        logic       bypass;
    } path_t;

    // Candidate base ticks, all in the reference domain
    typedef struct packed {
        logic main;
        logic fast;
        logic fast_q;
        logic slow;
        logic hib;
        logic pll_half;
    } ticks_t;

    localparam path_t PATH_RESET = '{src: SRC_FAST, bypass: 1'b1};

    function automatic logic path_ok(path_t p, logic main_off, logic fast_off, logic pd);
        logic ok;
        if (!p.bypass) begin
            ok = !pd;
        end else begin
            case (p.src)
                SRC_MAIN:             ok = !main_off;
                SRC_FAST, SRC_FAST_Q: ok = !fast_off;
                SRC_SLOW, SRC_HIB:    ok = 1'b1;
                default:              ok = 1'b0;
            endcase
        end
        return ok;
    endfunction

    function automatic logic pick_tick(path_t p, ticks_t t);
        logic k;
        if (!p.bypass) begin
            k = t.pll_half;
        end else begin
            case (p.src)
                SRC_MAIN:   k = t.main;
                SRC_FAST:   k = t.fast;
                SRC_FAST_Q: k = t.fast_q;
                SRC_SLOW:   k = t.slow;
                SRC_HIB:    k = t.hib;
                default:    k = 1'b0;
            endcase
        end
        return k;
    endfunction

endpackage

// File: rtl/clkctl_ediv.sv
module clkctl_ediv #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         run,
    input  logic [W-1:0] ratio_m1,
    output logic         pulse
);
    logic [W-1:0] cnt;
    logic [W-1:0] lim;

    assign pulse = run && tick && (cnt >= lim);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            lim <= ratio_m1;
        end else if (!run) begin
            cnt <= '0;
            lim <= ratio_m1;
        end else if (tick) begin
            if (cnt >= lim) begin
                cnt <= '0;
                lim <= ratio_m1;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    AST_LIM_HOLD: assert property (@(posedge clk) disable iff (rst)
        (run && !pulse) |=> (lim == $past(lim)))
        else $error("ratio changed inside a period"); // R9

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        run |-> (cnt <= lim))
        else $error("count beyond ratio"); // R3

endmodule

// File: rtl/clkctl_merge.sv
module clkctl_merge
    import clkctl_pkg::*;
#(
    parameter int DIV_W = 6
) (
    input  logic [2:0]       p_src,
    input  logic             p_bypass,
    input  logic             p_use_div,
    input  logic [DIV_W-1:0] p_div,
    input  logic             p_pd,
    input  logic             s_override,
    input  logic [2:0]       s_src,
    input  logic             s_bypass,
    input  logic             s_use_div,
    input  logic [DIV_W-1:0] s_div,
    input  logic             s_pd,
    input  logic             dsleep,
    input  logic [2:0]       d_src,
    input  logic             d_bypass,
    input  logic             d_use_div,
    input  logic [DIV_W-1:0] d_div,
    output path_t            req_path,
    output logic             req_use_div,
    output logic [DIV_W-1:0] req_div,
    output logic             req_pd
);
    path_t            run_path;
    logic             run_use_div;
    logic [DIV_W-1:0] run_div;

    // Run-mode fields: secondary group wins when override is set
    always_comb begin
        if (s_override) begin
            run_path    = '{src: s_src, bypass: s_bypass};
            run_use_div = s_use_div;
            run_div     = s_div;
            req_pd      = s_pd;
        end else begin
            run_path    = '{src: p_src, bypass: p_bypass};
            run_use_div = p_use_div;
            run_div     = p_div;
            req_pd      = p_pd;
        end
    end

    // Deep-sleep group replaces path and divider, never power-down
    always_comb begin
        if (dsleep) begin
            req_path    = '{src: d_src, bypass: d_bypass};
            req_use_div = d_use_div;
            req_div     = d_div;
        end else begin
            req_path    = run_path;
            req_use_div = run_use_div;
            req_div     = run_div;
        end
    end

endmodule

// File: rtl/clkctl_top.sv
module clkctl_top
    import clkctl_pkg::*;
#(
    parameter int DIV_W      = 6,
    parameter int PWM_CODE_W = 3,
    parameter int ADC_RATIO  = 25,
    parameter int FAST_QDIV  = 4,
    parameter int PLL_PRE    = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  pll_tick,
    input  logic                  main_tick,
    input  logic                  fast_tick,
    input  logic                  slow_tick,
    input  logic                  hib_tick,
    input  logic [2:0]            p_src,
    input  logic                  p_bypass,
    input  logic                  p_use_div,
    input  logic [DIV_W-1:0]      p_div,
    input  logic                  p_pd,
    input  logic                  main_off,
    input  logic                  fast_off,
    input  logic                  pwm_use_div,
    input  logic [PWM_CODE_W-1:0] pwm_code,
    input  logic                  s_override,
    input  logic [2:0]            s_src,
    input  logic                  s_bypass,
    input  logic                  s_use_div,
    input  logic [DIV_W-1:0]      s_div,
    input  logic                  s_pd,
    input  logic                  dsleep,
    input  logic [2:0]            d_src,
    input  logic                  d_bypass,
    input  logic                  d_use_div,
    input  logic [DIV_W-1:0]      d_div,
    output logic                  sys_en,
    output logic                  pwm_en,
    output logic                  adc_en,
    output logic                  sel_bad
);
    localparam int PWM_W  = 1 << PWM_CODE_W;
    localparam int ADC_W  = $clog2(ADC_RATIO);
    localparam int FQ_W   = $clog2(FAST_QDIV);
    localparam int PRE_W  = $clog2(PLL_PRE);

    path_t            req_path;
    path_t            act_path;
    logic             req_use_div;
    logic             req_pd;
    logic [DIV_W-1:0] req_div;
    logic [DIV_W-1:0] sys_ratio;
    logic [PWM_W-1:0] pwm_ratio;
    ticks_t           ticks;
    logic             base_tick;
    logic             act_ok;
    logic             sys_pulse;
    logic             pwm_pulse;

    clkctl_merge #(.DIV_W(DIV_W)) u_merge (
        .p_src(p_src), .p_bypass(p_bypass), .p_use_div(p_use_div), .p_div(p_div), .p_pd(p_pd),
        .s_override(s_override), .s_src(s_src), .s_bypass(s_bypass),
        .s_use_div(s_use_div), .s_div(s_div), .s_pd(s_pd),
        .dsleep(dsleep), .d_src(d_src), .d_bypass(d_bypass),
        .d_use_div(d_use_div), .d_div(d_div),
        .req_path(req_path), .req_use_div(req_use_div), .req_div(req_div), .req_pd(req_pd)
    );

    // Fixed prescalers feeding the source mux
    clkctl_ediv #(.W(PRE_W)) u_pll_pre (
        .clk(clk), .rst(rst), .tick(pll_tick), .run(!req_pd),
        .ratio_m1(PRE_W'(PLL_PRE - 1)), .pulse(ticks.pll_half)
    );

    clkctl_ediv #(.W(FQ_W)) u_fast_q (
        .clk(clk), .rst(rst), .tick(fast_tick), .run(!fast_off),
        .ratio_m1(FQ_W'(FAST_QDIV - 1)), .pulse(ticks.fast_q)
    );

    assign ticks.main = main_tick;
    assign ticks.fast = fast_tick && !fast_off;
    assign ticks.slow = slow_tick;
    assign ticks.hib  = hib_tick;

    // Active path is swapped only at a period boundary or when dead
    assign base_tick = pick_tick(act_path, ticks);
    assign act_ok    = path_ok(act_path, main_off, fast_off, req_pd);
    assign sel_bad   = !path_ok(req_path, main_off, fast_off, req_pd);
    assign sys_ratio = rst ? '0 : (req_use_div ? req_div : '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            act_path <= PATH_RESET;
        end else if (!act_ok || sys_pulse) begin
            act_path <= req_path;
        end
    end

    clkctl_ediv #(.W(DIV_W)) u_sys_div (
        .clk(clk), .rst(rst), .tick(base_tick), .run(act_ok),
        .ratio_m1(sys_ratio), .pulse(sys_pulse)
    );

    assign sys_en = sys_pulse;

    // PWM branch counts system pulses
    assign pwm_ratio = (PWM_W'(2) << pwm_code) - 1'b1;

    clkctl_ediv #(.W(PWM_W)) u_pwm_div (
        .clk(clk), .rst(rst), .tick(sys_pulse), .run(pwm_use_div),
        .ratio_m1(pwm_ratio), .pulse(pwm_pulse)
    );

    assign pwm_en = pwm_use_div ? pwm_pulse : sys_pulse;

    // ADC branch counts raw PLL ticks
    clkctl_ediv #(.W(ADC_W)) u_adc_div (
        .clk(clk), .rst(rst), .tick(pll_tick), .run(!req_pd),
        .ratio_m1(ADC_W'(ADC_RATIO - 1)), .pulse(adc_en)
    );

    AST_SYS_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        sys_en |-> (pll_tick || main_tick || fast_tick || slow_tick || hib_tick))
        else $error("system pulse without source tick"); // R1

    AST_PWM_IN_SYS: assert property (@(posedge clk) disable iff (rst)
        pwm_en |-> sys_en)
        else $error("pwm pulse outside system pulse"); // R6

    AST_ADC_GATED: assert property (@(posedge clk) disable iff (rst)
        adc_en |-> (pll_tick && !req_pd))
        else $error("adc pulse while pll down"); // R7

    AST_RESET_PATH: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!sys_en || fast_tick))
        else $error("first path after reset not internal fast"); // R10

endmodule

// File: tb/sim_clkctl_top.sv
`timescale 1ns/1ps
module sim_clkctl_top;
    localparam int DIV_W = 6;
    localparam int WIN   = 4200;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    int bc = 0;
    logic pll_tick, main_tick, fast_tick, slow_tick, hib_tick;
    logic [2:0] p_src = 3'd1, s_src = 3'd0, d_src = 3'd0;
    logic p_bypass = 1'b1, p_use_div = 1'b0, p_pd = 1'b0;
    logic [DIV_W-1:0] p_div = '0, s_div = '0, d_div = '0;
    logic main_off = 1'b0, fast_off = 1'b0, pwm_use_div = 1'b0;
    logic [2:0] pwm_code = 3'd0;
    logic s_override = 1'b0, s_bypass = 1'b1, s_use_div = 1'b0, s_pd = 1'b0;
    logic dsleep = 1'b0, d_bypass = 1'b1, d_use_div = 1'b0;
    logic sys_en, pwm_en, adc_en, sel_bad;

    always @(negedge clk) bc <= bc + 1;
    assign pll_tick  = 1'b1;
    assign main_tick = (bc % 3) == 0;
    assign fast_tick = (bc % 2) == 0;
    assign slow_tick = (bc % 7) == 0;
    assign hib_tick  = (bc % 5) == 0;

    clkctl_top #(.DIV_W(DIV_W)) u0 (
        .clk(clk), .rst(rst), .pll_tick(pll_tick), .main_tick(main_tick),
        .fast_tick(fast_tick), .slow_tick(slow_tick), .hib_tick(hib_tick),
        .p_src(p_src), .p_bypass(p_bypass), .p_use_div(p_use_div), .p_div(p_div), .p_pd(p_pd),
        .main_off(main_off), .fast_off(fast_off), .pwm_use_div(pwm_use_div), .pwm_code(pwm_code),
        .s_override(s_override), .s_src(s_src), .s_bypass(s_bypass), .s_use_div(s_use_div),
        .s_div(s_div), .s_pd(s_pd), .dsleep(dsleep), .d_src(d_src), .d_bypass(d_bypass),
        .d_use_div(d_use_div), .d_div(d_div),
        .sys_en(sys_en), .pwm_en(pwm_en), .adc_en(adc_en), .sel_bad(sel_bad)
    );

    typedef struct {
        int rq;
        int sys;
        int pwm;
        int adc;
        int bad;
    } exp_t;

    exp_t exp_q[$];
    int checks = 0;
    int errors = 0;
    int done_cnt = 0;
    bit finished = 1'b0;

    task automatic cmp(int rq, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL R%0d %s actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    // Monitor: pops an expectation, counts pulses over a full window
    initial begin
        forever begin
            exp_t e;
            int ns, np, na, b;
            wait (exp_q.size() > 0);
            e = exp_q.pop_front();
            ns = 0; np = 0; na = 0;
            @(negedge clk);
            b = int'(sel_bad);
            for (int i = 0; i < WIN; i++) begin
                ns += int'(sys_en);
                np += int'(pwm_en);
                na += int'(adc_en);
                @(negedge clk);
            end
            cmp(e.rq, "sys_en count", ns, e.sys);
            cmp(e.rq, "pwm_en count", np, e.pwm);
            cmp(e.rq, "adc_en count", na, e.adc);
            cmp(e.rq, "sel_bad", b, e.bad);
            done_cnt++;
        end
    end

    // Driver: lets the config settle, then queues an expectation
    task automatic expect_rates(int rq, int s, int p, int a, int b);
        exp_t e;
        int target;
        repeat (300) @(negedge clk);
        e.rq = rq; e.sys = s; e.pwm = p; e.adc = a; e.bad = b;
        target = done_cnt + 1;
        exp_q.push_back(e);
        wait (done_cnt == target);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        cmp(10, "sel_bad after reset", int'(sel_bad), 0);   // R10

        expect_rates(10, 2100, 2100, 168, 0);               // R10 internal fast, undivided

        // R1 source codes with bypass set
        p_src = 3'd0; expect_rates(1, 1400, 1400, 168, 0);  // R1 main, period 3
        p_src = 3'd2; expect_rates(1, 525, 525, 168, 0);    // R1 fast / 4, period 8
        p_src = 3'd3; expect_rates(1, 600, 600, 168, 0);    // R1 slow, period 7
        p_src = 3'd4; expect_rates(1, 840, 840, 168, 0);    // R1 hibernation, period 5

        // R2 PLL halved
        p_bypass = 1'b0; expect_rates(2, 2100, 2100, 168, 0);

        // R3 system divider
        p_use_div = 1'b1; p_div = 6'd4;
        expect_rates(3, 420, 420, 168, 0);                  // R3 period 10
        p_bypass = 1'b1; p_src = 3'd0; p_div = 6'd6;
        expect_rates(3, 200, 200, 168, 0);                  // R3 main period 21
        p_use_div = 1'b0;

        // R6 PWM divider on PLL path, system period 2
        p_bypass = 1'b0; pwm_use_div = 1'b1; pwm_code = 3'd0;
        expect_rates(6, 2100, 1050, 168, 0);                // R6 ratio 2
        pwm_code = 3'd1;
        expect_rates(6, 2100, 525, 168, 0);                 // R6 ratio 4
        pwm_use_div = 1'b0;

        // R4 secondary override
        p_bypass = 1'b1; p_src = 3'd0;
        s_override = 1'b1; s_src = 3'd3; s_bypass = 1'b1;
        expect_rates(4, 600, 600, 168, 0);                  // R4 secondary source
        s_bypass = 1'b0; s_pd = 1'b1;
        expect_rates(4, 0, 0, 0, 1);                        // R4 secondary power-down
        s_override = 1'b0; s_pd = 1'b0;

        // R5 deep sleep
        p_bypass = 1'b0; dsleep = 1'b1; d_src = 3'd4; d_bypass = 1'b1;
        expect_rates(5, 840, 840, 168, 0);                  // R5 deep-sleep source
        d_use_div = 1'b1; d_div = 6'd4;
        expect_rates(5, 168, 168, 168, 0);                  // R5 deep-sleep divider
        dsleep = 1'b0;

        // R7 ADC off under power-down, oscillator path unaffected
        p_bypass = 1'b1; p_src = 3'd1; p_pd = 1'b1;
        expect_rates(7, 2100, 2100, 0, 0);

        // R8 unusable selections
        p_bypass = 1'b0;
        expect_rates(8, 0, 0, 0, 1);                        // R8 PLL powered down
        p_pd = 1'b0; p_bypass = 1'b1; p_src = 3'd0; main_off = 1'b1;
        expect_rates(8, 0, 0, 168, 1);                      // R8 main disabled
        main_off = 1'b0; p_src = 3'd6;
        expect_rates(8, 0, 0, 168, 1);                      // R8 reserved code
        p_src = 3'd2; fast_off = 1'b1;
        expect_rates(8, 0, 0, 168, 1);                      // R8 fast / 4 disabled
        fast_off = 1'b0;

        // R9 divider change completes the running period first
        begin
            int g;
            p_bypass = 1'b0; p_use_div = 1'b1; p_div = 6'd49;
            repeat (300) @(negedge clk);
            while (!sys_en) @(negedge clk);
            @(negedge clk);
            g = 1;
            p_div = 6'd0;
            while (!sys_en) begin @(negedge clk); g++; end
            cmp(9, "gap after divider change", g, 100);     // R9
            @(negedge clk);
            g = 1;
            while (!sys_en) begin @(negedge clk); g++; end
            cmp(9, "gap with new divider", g, 2);           // R9
        end

        finish_run();
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

endmodule